// File: doc/BRIEF.md
# Masked Fault Latch Interrupt Controller

This block captures eight asynchronous fault signals into sticky flags and raises one active-high, level-sensitive interrupt whenever a flag is set whose enable bit is 1. The flags are read back as status register 0. The enable mask is written four bits at a time: one command loads the lower half and another loads the upper half.

Flags are cleared by a clear command that names a half and carries a 4-bit pattern. The request is held until the end of the serial message. It is applied only if that message ends without a framing error. It is also withheld from any flag whose synchronized fault input toggled while the message was open, so an event that arrives during the message cannot be lost. A fault that is still active sets its flag again at once. The serial shifter and the command decoder sit outside the block and drive its strobes.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset, status_o is 0x00, irq_o is 0 and every mask bit is 0.
- R2: A fault input held high across at least one rising clock edge sets its status_o bit three clock edges later. The bit stays set after the input returns low, until a clear removes it.
- R3: irq_o is 1 exactly when some status_o bit is 1 and its mask bit is also 1. With a zero mask, irq_o stays 0.
- R4: A mask write with mask_hi_i=0 loads cmd_data_i into mask bits 3:0. With mask_hi_i=1 it loads mask bits 7:4. The other half keeps its value. A 1 enables the flag.
- R5: A clear strobe with clr_hi_i=0 marks status bits 3:0 for clearing, and with clr_hi_i=1 it marks bits 7:4, where a data bit of 1 marks that flag. Marked flags drop on the edge that samples msg_end_i, provided frame_err_i is 0 in that cycle.
- R6: If the message ends with frame_err_i=1, no flag is cleared. The request is discarded and is not applied at a later message end.
- R7: A flag whose fault input changed level between msg_start_i and msg_end_i is not cleared by that message.
- R8: A flag whose fault input is still high stays set through a clear, and its interrupt stays asserted.
- R9: When only some of several pending flags are cleared, irq_o stays high in every cycle of that message and afterwards.
- R10: A message that carries no clear strobe leaves every status bit and irq_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 8 | Live fault signals, asynchronous |
| msg_start_i | input | 1 | One-cycle pulse at the start of a serial message |
| msg_end_i | input | 1 | One-cycle pulse at the end of a serial message |
| frame_err_i | input | 1 | Message was malformed; valid while msg_end_i is high |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_hi_i | input | 1 | Mask half select: 0 selects bits 3:0, 1 selects bits 7:4 |
| clr_wr_i | input | 1 | Clear request strobe |
| clr_hi_i | input | 1 | Clear half select: 0 selects bits 3:0, 1 selects bits 7:4 |
| cmd_data_i | input | 4 | Data nibble for a mask write or a clear request |
| status_o | output | 8 | Latched fault flags (status register 0) |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The hardest case to reach is a flag that is already set and marked for clearing, while its fault input toggles inside the same message. The bench opens a message, pulses that fault for one cycle, and waits for the edge to pass the synchronizer. Only then does it issue the clear and close the message. The flag must survive even though the input is low again. A neighbouring flag cleared by the same request must drop. To check that the interrupt never glitches on a partial clear, the bench samples irq_o at every falling edge through the whole message.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
    parameter int unsigned FLT_N = 8;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/fault_irq_sync.sv
module fault_irq_sync #(
    parameter int unsigned N = fault_irq_pkg::FLT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        typedef struct packed {
            logic s1;
            logic s2;
        } sync_t;

        sync_t cur_q, nxt_d;

        always_comb begin
            nxt_d.s1 = async_i[i];
            nxt_d.s2 = cur_q.s1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cur_q <= '0;
            else        cur_q <= nxt_d;
        end

        assign sync_o[i] = cur_q.s2;
    end
endmodule

// File: rtl/fault_irq_track.sv
module fault_irq_track #(
    parameter int unsigned N = fault_irq_pkg::FLT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flt_s_i,
    input  logic         msg_start_i,
    output logic [N-1:0] chg_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] chg;
    } trk_t;

    trk_t cur_q, nxt_d;
    logic [N-1:0] edge_w;

    always_comb begin
        edge_w    = flt_s_i ^ cur_q.prev;
        nxt_d     = cur_q;
        nxt_d.prev = flt_s_i;
        nxt_d.chg = (msg_start_i ? '0 : cur_q.chg) | edge_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign chg_o = cur_q.chg | edge_w;

    // R7: an edge on the synchronized fault must be recorded
    p_edge_recorded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_s_i != $past(flt_s_i)) |-> ((chg_o & (flt_s_i ^ $past(flt_s_i))) == (flt_s_i ^ $past(flt_s_i))));
endmodule

// File: rtl/fault_irq_core.sv
module fault_irq_core #(
    parameter int unsigned N = fault_irq_pkg::FLT_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   flt_s_i,
    input  logic [N-1:0]   chg_i,
    input  logic           msg_start_i,
    input  logic           msg_end_i,
    input  logic           frame_err_i,
    input  logic           mask_wr_i,
    input  logic           mask_hi_i,
    input  logic           clr_wr_i,
    input  logic           clr_hi_i,
    input  logic [N/2-1:0] data_i,
    output logic [N-1:0]   lat_o,
    output logic [N-1:0]   mask_o
);
    import fault_irq_pkg::*;
    localparam int unsigned H = N / 2;

    typedef struct packed {
        logic [N-1:0] lat;
        logic [N-1:0] mask;
        logic [N-1:0] pend;
    } core_t;

    core_t cur_q, nxt_d;
    logic [N-1:0] clr_wide_w;
    logic [N-1:0] pend_eff_w;
    logic [N-1:0] clr_vec_w;
    half_e        mhalf_w, chalf_w;

    always_comb begin
        mhalf_w = half_e'(mask_hi_i);
        chalf_w = half_e'(clr_hi_i);
        nxt_d   = cur_q;

        if (mask_wr_i) begin
            if (mhalf_w == HALF_HI) nxt_d.mask[N-1:H] = data_i;
            else                    nxt_d.mask[H-1:0] = data_i;
        end

        clr_wide_w = (chalf_w == HALF_HI) ? {data_i, {H{1'b0}}}
                                          : {{H{1'b0}}, data_i};
        pend_eff_w = (msg_start_i ? '0 : cur_q.pend)
                   | (clr_wr_i ? clr_wide_w : '0);
        nxt_d.pend = pend_eff_w;

        clr_vec_w = '0;
        if (msg_end_i) begin
            nxt_d.pend = '0;
            if (!frame_err_i) clr_vec_w = pend_eff_w & ~chg_i;
        end

        nxt_d.lat = (cur_q.lat & ~clr_vec_w) | flt_s_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign lat_o  = cur_q.lat;
    assign mask_o = cur_q.mask;

    // R2: a synchronized fault is latched on the next edge
    p_fault_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_s_i) |=> ((lat_o & $past(flt_s_i)) == $past(flt_s_i)));

    // R4: half-wise mask writes
    p_mask_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_i && !mask_hi_i) |=> (mask_o[H-1:0] == $past(data_i)
                                       && mask_o[N-1:H] == $past(mask_o[N-1:H])));
    p_mask_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_i && mask_hi_i) |=> (mask_o[N-1:H] == $past(data_i)
                                      && mask_o[H-1:0] == $past(mask_o[H-1:0])));

    // R5 / R6: a flag only drops right after a valid message end
    p_clear_only_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(lat_o) & ~lat_o)) |-> $past(msg_end_i && !frame_err_i));

    // R7: flags that changed during the message survive its end
    p_changed_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_end_i |=> ((lat_o & $past(chg_i & lat_o)) == $past(chg_i & lat_o)));
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] fault_i,
    input  logic       msg_start_i,
    input  logic       msg_end_i,
    input  logic       frame_err_i,
    input  logic       mask_wr_i,
    input  logic       mask_hi_i,
    input  logic       clr_wr_i,
    input  logic       clr_hi_i,
    input  logic [3:0] cmd_data_i,
    output logic [7:0] status_o,
    output logic       irq_o
);
    localparam int unsigned N = fault_irq_pkg::FLT_N;

    logic [N-1:0] flt_s_w;
    logic [N-1:0] chg_w;
    logic [N-1:0] lat_w;
    logic [N-1:0] mask_w;

    fault_irq_sync #(.N(N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fault_i),
        .sync_o  (flt_s_w)
    );

    fault_irq_track #(.N(N)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .flt_s_i     (flt_s_w),
        .msg_start_i (msg_start_i),
        .chg_o       (chg_w)
    );

    fault_irq_core #(.N(N)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .flt_s_i     (flt_s_w),
        .chg_i       (chg_w),
        .msg_start_i (msg_start_i),
        .msg_end_i   (msg_end_i),
        .frame_err_i (frame_err_i),
        .mask_wr_i   (mask_wr_i),
        .mask_hi_i   (mask_hi_i),
        .clr_wr_i    (clr_wr_i),
        .clr_hi_i    (clr_hi_i),
        .data_i      (cmd_data_i),
        .lat_o       (lat_w),
        .mask_o      (mask_w)
    );

    assign status_o = lat_w;
    assign irq_o    = |(lat_w & mask_w);

    // R3: the interrupt needs a latched flag behind it
    p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o != '0));

    // R8: a still-active synchronized fault keeps its flag through any clear
    p_active_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_s_w) |=> ((status_o & $past(flt_s_w)) == $past(flt_s_w)));
endmodule

// File: tb/fault_irq_ctrl_bench.sv
module fault_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fault_i = '0;
    logic       msg_start_i = 1'b0, msg_end_i = 1'b0, frame_err_i = 1'b0;
    logic       mask_wr_i = 1'b0, mask_hi_i = 1'b0;
    logic       clr_wr_i = 1'b0, clr_hi_i = 1'b0;
    logic [3:0] cmd_data_i = '0;
    logic [7:0] status_o;
    logic       irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fault_irq_ctrl u_fault_irq_ctrl (.*);

    // each entry: {fault pattern, mask}
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{
        16'h01_01, 16'h80_7F, 16'h0F_F0, 16'hF0_F0, 16'h24_20, 16'h00_FF
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic set_mask(input logic [7:0] m);
        mask_wr_i = 1'b1; mask_hi_i = 1'b0; cmd_data_i = m[3:0]; step(1);
        mask_hi_i = 1'b1; cmd_data_i = m[7:4]; step(1);
        mask_wr_i = 1'b0; mask_hi_i = 1'b0;
    endtask

    task automatic write_half(input logic hi, input logic [3:0] d);
        mask_wr_i = 1'b1; mask_hi_i = hi; cmd_data_i = d; step(1);
        mask_wr_i = 1'b0; mask_hi_i = 1'b0;
    endtask

    task automatic pulse_fault(input logic [7:0] f);
        fault_i = f; step(1); fault_i = '0; step(3);
    endtask

    task automatic frame(input logic lo_en, input logic [3:0] lo,
                         input logic hi_en, input logic [3:0] hi, input logic err);
        msg_start_i = 1'b1; step(1); msg_start_i = 1'b0;
        if (lo_en) begin clr_wr_i = 1'b1; clr_hi_i = 1'b0; cmd_data_i = lo; step(1); end
        if (hi_en) begin clr_wr_i = 1'b1; clr_hi_i = 1'b1; cmd_data_i = hi; step(1); end
        clr_wr_i = 1'b0; clr_hi_i = 1'b0;
        msg_end_i = 1'b1; frame_err_i = err; step(1);
        msg_end_i = 1'b0; frame_err_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        chk("R1 status", status_o, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        fault_i = 8'hFF; step(4); fault_i = '0; step(3);
        chk("R1 mask zero blocks irq", {7'd0, irq_o}, 8'h00);
        frame(1'b1, 4'hF, 1'b1, 4'hF, 1'b0);
        chk("R5 clear all", status_o, 8'h00);

        // table walk: R2, R3, R5
        for (int v = 0; v < NV; v++) begin
            set_mask(VEC[v][7:0]);
            pulse_fault(VEC[v][15:8]);
            chk("R2 latched", status_o, VEC[v][15:8]);
            chk("R3 irq", {7'd0, irq_o}, {7'd0, |(VEC[v][15:8] & VEC[v][7:0])});
            frame(1'b1, 4'hF, 1'b1, 4'hF, 1'b0);
            chk("R5 cleared", status_o, 8'h00);
        end

        // R4: half-wise mask writes
        set_mask(8'h00);
        write_half(1'b1, 4'hF);
        pulse_fault(8'h02);
        chk("R4 upper mask does not enable bit1", {7'd0, irq_o}, 8'h00);
        write_half(1'b0, 4'h2);
        chk("R4 lower mask enables bit1", {7'd0, irq_o}, 8'h01);
        write_half(1'b1, 4'h0);
        chk("R4 upper write keeps lower", {7'd0, irq_o}, 8'h01);
        write_half(1'b0, 4'h0);
        chk("R4 lower write disables", {7'd0, irq_o}, 8'h00);
        frame(1'b1, 4'hF, 1'b0, 4'h0, 1'b0);

        // R5: one half only
        pulse_fault(8'h11);
        frame(1'b0, 4'h0, 1'b1, 4'h1, 1'b0);
        chk("R5 upper half only", status_o, 8'h01);
        frame(1'b1, 4'h1, 1'b0, 4'h0, 1'b0);

        // R6 / R10: framing error and empty message
        pulse_fault(8'h03);
        frame(1'b1, 4'h3, 1'b0, 4'h0, 1'b1);
        chk("R6 framing error keeps flags", status_o, 8'h03);
        frame(1'b0, 4'h0, 1'b0, 4'h0, 1'b0);
        chk("R6 R10 request discarded, empty message no change", status_o, 8'h03);
        set_mask(8'h01);
        frame(1'b0, 4'h0, 1'b0, 4'h0, 1'b0);
        chk("R10 irq unchanged", {7'd0, irq_o}, 8'h01);
        frame(1'b1, 4'h3, 1'b0, 4'h0, 1'b0);
        chk("R5 valid clear", status_o, 8'h00);

        // R7: change during the message protects the flag
        pulse_fault(8'h03);
        msg_start_i = 1'b1; step(1); msg_start_i = 1'b0;
        fault_i = 8'h01; step(1); fault_i = 8'h00; step(4);
        clr_wr_i = 1'b1; clr_hi_i = 1'b0; cmd_data_i = 4'h3; step(1);
        clr_wr_i = 1'b0;
        msg_end_i = 1'b1; step(1); msg_end_i = 1'b0;
        chk("R7 toggled flag kept, other cleared", status_o, 8'h01);
        frame(1'b1, 4'h1, 1'b0, 4'h0, 1'b0);
        chk("R7 next message clears", status_o, 8'h00);

        // R8: still-active fault re-latches
        set_mask(8'h40);
        fault_i = 8'h40; step(4);
        frame(1'b0, 4'h0, 1'b1, 4'hF, 1'b0);
        chk("R8 active fault stays", status_o, 8'h40);
        chk("R8 irq stays", {7'd0, irq_o}, 8'h01);
        fault_i = '0; step(3);
        frame(1'b0, 4'h0, 1'b1, 4'hF, 1'b0);
        chk("R8 cleared once gone", status_o, 8'h00);

        // R9: partial clear never drops the interrupt
        set_mask(8'hFF);
        pulse_fault(8'h11);
        begin
            logic dropped;
            dropped = 1'b0;
            msg_start_i = 1'b1; step(1); msg_start_i = 1'b0;
            if (!irq_o) dropped = 1'b1;
            clr_wr_i = 1'b1; clr_hi_i = 1'b0; cmd_data_i = 4'h1; step(1);
            clr_wr_i = 1'b0;
            if (!irq_o) dropped = 1'b1;
            msg_end_i = 1'b1; step(1); msg_end_i = 1'b0;
            for (int k = 0; k < 4; k++) begin
                if (!irq_o) dropped = 1'b1;
                step(1);
            end
            chk("R9 irq never dropped", {7'd0, dropped}, 8'h00);
            chk("R9 remaining flag", status_o, 8'h10);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule